// File: doc/BRIEF.md
# Flash Lock-Bit Protection Controller

This block holds the write-protection state of a flash device that is split into many erase blocks. It keeps one lock bit for each block and a single master lock bit above them. For every request it decides whether the operation may go ahead. The requests are block erase, program, set one block lock, clear all block locks, and set the master lock. The decision depends on the addressed block's lock bit, the master lock bit and the level of the reset/protect pin. That pin level arrives as a two-bit digital code: low, normal high, or elevated high voltage.

Each accepted request (`req_valid` high at a rising edge) is answered one cycle later. Exactly one of `grant` and `deny` is high in that cycle. The lock state is updated in the same cycle. Erase and program never change the lock state, and the array operation itself is left to the surrounding logic. Behind a normal-high pin, the master lock bit protects the block lock bits. The elevated voltage on the pin acts as an override. The master lock bit has no clear command, so only the reset input removes it.

Top module: `flash_lock_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every block lock bit and the master lock bit are cleared, and `grant` and `deny` are 0 in the next cycle.
- R2: Erase (`req_op`=1) or program (`req_op`=2) with the pin at normal high (`pin_lvl`=2'b01) is granted exactly when the addressed block's lock bit is 0.
- R3: Erase or program with the pin at elevated voltage (`pin_lvl`=2'b10) is granted whatever the block lock bit is, and it leaves all lock bits unchanged.
- R4: With the master lock bit at 0, set-lock (`req_op`=3) and clear-locks (`req_op`=4) are granted at either high pin level (2'b01 or 2'b10).
- R5: With the master lock bit at 1, set-lock and clear-locks are denied at normal high and granted at elevated voltage.
- R6: Set-master (`req_op`=5) is granted only at elevated voltage and is denied at normal high.
- R7: With the pin low (2'b00), and for the reserved code 2'b11, every request is denied.
- R8: A granted set-lock sets only the bit of block `req_blk`. A granted clear-locks clears every block lock bit. Both changes appear in the cycle after the request.
- R9: Once set, the master lock bit stays 1 until `rst`, whatever requests follow.
- R10: In the cycle after each accepted request exactly one of `grant` and `deny` is 1. Both are 0 when no request was accepted. The codes `req_op`=0, 6 and 7 are always denied.
- R11: A denied request leaves the block lock bits and the master lock bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high power-on reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation: 1 erase, 2 program, 3 set block lock, 4 clear all locks, 5 set master lock |
| req_blk | input | IDX_W | Addressed block index |
| pin_lvl | input | 2 | Reset/protect pin level: 00 low, 01 normal high, 10 elevated, 11 reserved |
| grant | output | 1 | Previous-cycle request was allowed |
| deny | output | 1 | Previous-cycle request was refused |
| block_locks | output | NUM_BLOCKS | Current block lock bits |
| master_lock | output | 1 | Current master lock bit |

## Verification
The assertions take for granted that `pin_lvl`, `req_op` and `req_blk` are stable across the sampling edge of a request. They also take for granted that `req_blk` addresses an existing block. The bench meets the first condition by driving every input on the falling edge. It meets the second by using four blocks with a two-bit index. The bench sweeps every operation code, every pin code, every block and every lock pattern under both master lock states. It builds each starting state through the block's own commands after a reset.

// File: rtl/flp_pkg.sv
package flp_pkg;

    typedef enum logic [1:0] {
        PIN_LOW   = 2'b00,
        PIN_HIGH  = 2'b01,
        PIN_BOOST = 2'b10,
        PIN_RSVD  = 2'b11
    } pin_e;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_ERASE    = 3'd1,
        OP_PROG     = 3'd2,
        OP_LOCK_SET = 3'd3,
        OP_LOCK_CLR = 3'd4,
        OP_MSTR_SET = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } op_e;

    typedef struct packed {
        logic grant;
        logic deny;
    } resp_t;

    typedef struct packed {
        logic set_blk;
        logic clr_all;
        logic set_mstr;
    } upd_t;

    function automatic logic permit(input op_e op, input pin_e pin,
                                    input logic blk_locked,
                                    input logic mstr_locked,
                                    input logic in_range);
        logic boost;
        logic powered;
        boost   = (pin == PIN_BOOST);
        powered = (pin == PIN_HIGH) || boost;
        if (!powered) return 1'b0;
        case (op)
            OP_ERASE, OP_PROG:       return in_range && (boost || !blk_locked);
            OP_LOCK_SET:             return in_range && (boost || !mstr_locked);
            OP_LOCK_CLR:             return boost || !mstr_locked;
            OP_MSTR_SET:             return boost;
            default:                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/flp_decide.sv
module flp_decide
    import flp_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  valid,
    input  logic [2:0]            op_raw,
    input  logic [IDX_W-1:0]      blk,
    input  logic [1:0]            pin_raw,
    input  logic [NUM_BLOCKS-1:0] locks,
    input  logic                  mstr,
    output logic                  allow,
    output upd_t                  upd
);
    logic blk_locked;
    logic in_range;
    op_e  op;

    assign op       = op_e'(op_raw);
    assign in_range = (32'(blk) < NUM_BLOCKS);

    always_comb begin
        blk_locked = 1'b0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (32'(blk) == i) blk_locked = locks[i];
        end
    end

    always_comb begin
        allow        = valid && permit(op, pin_e'(pin_raw), blk_locked, mstr, in_range);
        upd.set_blk  = allow && (op == OP_LOCK_SET);
        upd.clr_all  = allow && (op == OP_LOCK_CLR);
        upd.set_mstr = allow && (op == OP_MSTR_SET);
    end
endmodule

// File: rtl/flp_lock_bank.sv
module flp_lock_bank #(
    parameter int NUM_BLOCKS = 16,
    localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  clr_all,
    output logic [NUM_BLOCKS-1:0] locks
);
    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                locks[g] <= 1'b0;
            else if (clr_all)
                locks[g] <= 1'b0;
            else if (set_en && (32'(set_idx) == g))
                locks[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/flp_master_reg.sv
module flp_master_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    output logic mstr
);
    always_ff @(posedge clk) begin
        if (rst)
            mstr <= 1'b0;
        else if (set_en)
            mstr <= 1'b1;
    end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flp_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [IDX_W-1:0]      req_blk,
    input  logic [1:0]            pin_lvl,
    output logic                  grant,
    output logic                  deny,
    output logic [NUM_BLOCKS-1:0] block_locks,
    output logic                  master_lock
);
    logic  allow;
    upd_t  upd;
    resp_t resp_q;

    flp_decide #(.NUM_BLOCKS(NUM_BLOCKS)) u_decide (
        .valid   (req_valid),
        .op_raw  (req_op),
        .blk     (req_blk),
        .pin_raw (pin_lvl),
        .locks   (block_locks),
        .mstr    (master_lock),
        .allow   (allow),
        .upd     (upd)
    );

    flp_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_en  (upd.set_blk),
        .set_idx (req_blk),
        .clr_all (upd.clr_all),
        .locks   (block_locks)
    );

    flp_master_reg u_master (
        .clk    (clk),
        .rst    (rst),
        .set_en (upd.set_mstr),
        .mstr   (master_lock)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.grant <= allow;
            resp_q.deny  <= req_valid && !allow;
        end
    end

    assign grant = resp_q.grant;
    assign deny  = resp_q.deny;
endmodule

// File: rtl/flp_checker.sv
module flp_checker #(
    parameter int NUM_BLOCKS = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [2:0]            req_op,
    input logic [1:0]            pin_lvl,
    input logic                  grant,
    input logic                  deny,
    input logic [NUM_BLOCKS-1:0] block_locks,
    input logic                  master_lock
);
    logic pend;
    logic pend_off;
    logic pend_mset_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend           <= 1'b0;
            pend_off       <= 1'b0;
            pend_mset_high <= 1'b0;
        end else begin
            pend           <= req_valid;
            pend_off       <= req_valid && (pin_lvl == 2'b00 || pin_lvl == 2'b11);
            pend_mset_high <= req_valid && (req_op == 3'd5) && (pin_lvl == 2'b01);
        end
    end

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        pend |-> (grant ^ deny)); // R10

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pend |-> (!grant && !deny)); // R10

    AST_PIN_OFF_DENY: assert property (@(posedge clk) disable iff (rst)
        pend_off |-> deny); // R7

    AST_MASTER_HIGH_DENY: assert property (@(posedge clk) disable iff (rst)
        pend_mset_high |-> deny); // R6

    AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (rst)
        master_lock |=> master_lock); // R9

    AST_DENY_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        deny |-> ($stable(block_locks) && $stable(master_lock))); // R11

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        (pend && grant && $past(req_op) == 3'd4) |-> (block_locks == '0)); // R8
endmodule

bind flash_lock_ctrl flp_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .pin_lvl     (pin_lvl),
    .grant       (grant),
    .deny        (deny),
    .block_locks (block_locks),
    .master_lock (master_lock)
);

// File: tb/tb_flash_lock_ctrl.sv
`timescale 1ns/1ps
module tb_flash_lock_ctrl;
    localparam int NB = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd0;
    logic [IW-1:0] req_blk = '0;
    logic [1:0]    pin_lvl = 2'b01;
    logic          grant;
    logic          deny;
    logic [NB-1:0] block_locks;
    logic          master_lock;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_lock_ctrl #(.NUM_BLOCKS(NB)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_blk(req_blk), .pin_lvl(pin_lvl), .grant(grant), .deny(deny),
        .block_locks(block_locks), .master_lock(master_lock)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; req_valid = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic issue(input int op, input int pin, input int blk);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); pin_lvl = 2'(pin); req_blk = IW'(blk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic bit model_allow(int op, int pin, int locks, int m, int blk);
        bit boost = (pin == 2);
        if (!(pin == 1 || boost)) return 1'b0;
        case (op)
            1, 2:    return boost || !locks[blk];
            3, 4:    return boost || !m;
            5:       return boost;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        do_reset();
        check("R1 grant after reset", int'(grant), 0);
        check("R1 deny after reset", int'(deny), 0);
        check("R1 locks after reset", int'(block_locks), 0);
        check("R1 master after reset", int'(master_lock), 0);

        issue(5, 2, 0);
        check("R6 master set at boost", int'(master_lock), 1);
        @(negedge clk);
        check("R10 idle no response", int'({grant, deny}), 0);
        issue(4, 2, 0);
        check("R9 master survives clear", int'(master_lock), 1);
        do_reset();
        check("R9 master cleared by reset", int'(master_lock), 0);

        for (int m = 0; m < 2; m++) begin
            for (int pat = 0; pat < 16; pat++) begin
                for (int op = 0; op < 8; op++) begin
                    for (int pin = 0; pin < 4; pin++) begin
                        for (int blk = 0; blk < NB; blk++) begin
                            bit    ok;
                            int    exp_locks;
                            int    exp_m;
                            string tag;
                            string stag;
                            do_reset();
                            for (int b = 0; b < NB; b++)
                                if (pat[b]) issue(3, 2, b);
                            if (m == 1) issue(5, 2, 0);
                            ok = model_allow(op, pin, pat, m, blk);
                            exp_locks = pat;
                            exp_m = m;
                            if (ok && op == 3) exp_locks = pat | (1 << blk);
                            if (ok && op == 4) exp_locks = 0;
                            if (ok && op == 5) exp_m = 1;
                            if (pin == 0 || pin == 3)   tag = "R7";
                            else if (op == 1 || op == 2) tag = (pin == 1) ? "R2" : "R3";
                            else if (op == 3 || op == 4) tag = (m == 1) ? "R5" : "R4";
                            else if (op == 5)           tag = "R6";
                            else                        tag = "R10";
                            if (!ok)                    stag = "R11";
                            else if (op == 3 || op == 4) stag = "R8";
                            else if (op == 1 || op == 2) stag = "R3";
                            else                        stag = "R9";
                            issue(op, pin, blk);
                            check($sformatf("%s resp m=%0d pat=%0h op=%0d pin=%0d blk=%0d",
                                            tag, m, pat, op, pin, blk),
                                  int'({grant, deny}), ok ? 2 : 1);
                            check($sformatf("%s state m=%0d pat=%0h op=%0d pin=%0d blk=%0d",
                                            stag, m, pat, op, pin, blk),
                                  int'({master_lock, block_locks}), (exp_m << NB) | exp_locks);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule